// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block models a 4096-bit nonvolatile memory that a host reaches over three serial wires: a select line, a serial clock and a data input. The host sends a single output line back. A static organization input sets the array shape. High gives 256 words of 16 bits. Low gives 512 words of 8 bits. Seven instructions are decoded. Three of them read, write or erase one word. Two of them fill or clear the whole array. The last two open and close a programming lock, which is closed after reset.

All serial inputs are synchronised into the system clock domain, and their edges are found there. The serial clock must therefore run well below the system clock. A programming instruction takes effect when the select line falls. It then runs as a self-timed cycle whose length is a parameter counted in system clocks. While the cycle runs, the host can raise the select line and poll the data output: it reads low while the cycle is busy and high once the cycle has finished. The array is kept in registers, and reset sets every byte to all ones.

Top module: `mw_eeprom`

## Requirements
- R1: A frame is a start bit of 1, then a 2-bit opcode, then an address (8 bits when `org`=1, 9 bits when `org`=0), all sent MSB first. Each bit is sampled on a rising edge of `sk`. Zero bits that arrive while waiting for the start bit are skipped.
- R2: With `org`=1, word address a covers byte 2a (bits 15:8) and byte 2a+1 (bits 7:0) of a 512-byte store. With `org`=0, address a is byte a. Both views share the same storage.
- R3: Opcode 10 reads, 01 writes one word and 11 erases one word. Opcode 00 uses the top two address bits as a sub-code: 11 opens the lock, 00 closes it, 10 erases every cell and 01 writes one data word into every location. The remaining address bits are ignored.
- R4: After reset the lock is closed. While the lock is closed, write, erase, erase-all and write-all change no cell and start no busy cycle. The lock stays open until the close instruction arrives.
- R5: Read is accepted whatever the lock state. After the last address bit, `do_out` shows a 0 dummy bit. Each later rising `sk` edge moves `do_out` to the next data bit, MSB first.
- R6: During a read with `cs` held high, the address steps up by one after each word and wraps from the top of the array to 0, so words keep streaming.
- R7: A programming instruction starts its cycle when `cs` falls after a complete frame. The cycle lasts `PROG_CLKS` system clocks. While `cs` is high, `do_out` is 0 during the cycle and 1 after it.
- R8: `do_en` is 0 whenever `cs` is low, which means the output is released.
- R9: Erase and erase-all set the cells they cover to all ones. Write replaces the old word, with no need for an erase first. Write-all puts its data word into every location.
- R10: A frame that begins while a cycle is busy is ignored.
- R11: If `cs` falls before every bit of a frame (including its data) has arrived, the frame is discarded and has no effect.
- R12: After reset every byte of the store reads as 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org | input | 1 | Organization: 1 = 256x16, 0 = 512x8 |
| do_out | output | 1 | Serial data out / ready flag |
| do_en | output | 1 | Output enable for do_out (0 = high impedance) |

## Verification
Both organizations are exercised. A word written in the x16 view is read back byte by byte in the x8 view, so the test can tell whether the byte order and the address width follow the org input. Single-word writes use patterns with both halves set and both halves clear, and erase, write-all and erase-all are also run. A read straight after each of these shows whether the earlier content was fully replaced. A read that starts at the last word shows whether the address wraps to 0. The lock is tested closed after reset, open, and closed again, to show that it gates cell changes and busy cycles but leaves reads alone. Frames sent during a busy cycle and frames cut short are checked to have no effect. The length of the busy window is measured against `PROG_CLKS`.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned MW_BYTE_W  = 8;
  localparam int unsigned MW_WORD_W  = 2 * MW_BYTE_W;
  localparam int unsigned MW_ABITS   = 9;
  localparam int unsigned MW_OPC_W   = 2;
  localparam int unsigned MW_CMD_W   = MW_OPC_W + MW_ABITS;

  typedef enum logic [2:0] {
    OP_READ, OP_WRITE, OP_ERASE, OP_UNLOCK, OP_LOCK, OP_CLR_ALL, OP_FILL_ALL
  } mw_op_e;

  typedef enum logic [1:0] { WK_NONE, WK_ONE, WK_ALL } mw_wk_e;

  // opcode plus the two sub-code bits taken from the top of the address
  function automatic mw_op_e mw_decode(input logic [1:0] opc, input logic [1:0] sub);
    mw_op_e r;
    case (opc)
      2'b10:   r = OP_READ;
      2'b01:   r = OP_WRITE;
      2'b11:   r = OP_ERASE;
      default: case (sub)
                 2'b11:   r = OP_UNLOCK;
                 2'b00:   r = OP_LOCK;
                 2'b10:   r = OP_CLR_ALL;
                 default: r = OP_FILL_ALL;
               endcase
    endcase
    return r;
  endfunction

  function automatic logic mw_is_prog(input mw_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_CLR_ALL) || (op == OP_FILL_ALL);
  endfunction

  function automatic logic [4:0] mw_addr_len(input logic wide);
    return wide ? 5'(MW_ABITS - 1) : 5'(MW_ABITS);
  endfunction

  function automatic logic [4:0] mw_data_len(input logic wide);
    return wide ? 5'(MW_WORD_W) : 5'(MW_BYTE_W);
  endfunction

  // sequential read step, wrapping at the top of the active organization
  function automatic logic [MW_ABITS-1:0] mw_next_addr(input logic [MW_ABITS-1:0] a, input logic wide);
    logic [MW_ABITS-1:0] n;
    n = a + 1'b1;
    if (wide) n[MW_ABITS-1] = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise,
  output logic cs_fall
);
  logic [STAGES-1:0] cs_p, sk_p, di_p;
  logic sk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0;
      sk_q <= 1'b0; cs_q <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs};
      sk_p <= {sk_p[STAGES-2:0], sk};
      di_p <= {di_p[STAGES-2:0], di};
      sk_q <= sk_p[STAGES-1];
      cs_q <= cs_p[STAGES-1];
    end
  end

  assign cs_s    = cs_p[STAGES-1];
  assign di_s    = di_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-1] & ~sk_q;
  assign cs_fall = cs_q & ~cs_p[STAGES-1];
endmodule

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int unsigned ABITS  = MW_ABITS,
  parameter int unsigned BYTE_W = MW_BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mw_wk_e                wr_kind,
  input  logic                  wide,
  input  logic [ABITS-1:0]      wr_addr,
  input  logic [2*BYTE_W-1:0]   wr_data,
  input  logic [ABITS-1:0]      rd_addr,
  output logic [2*BYTE_W-1:0]   rd_word
);
  localparam int unsigned DEPTH = 1 << ABITS;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ABITS-1:0]  wr_hi, wr_lo, rd_hi, rd_lo;

  assign wr_hi = {wr_addr[ABITS-2:0], 1'b0};
  assign wr_lo = {wr_addr[ABITS-2:0], 1'b1};
  assign rd_hi = {rd_addr[ABITS-2:0], 1'b0};
  assign rd_lo = {rd_addr[ABITS-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      case (wr_kind)
        WK_ONE: begin
          if (wide) begin
            mem[wr_hi] <= wr_data[2*BYTE_W-1:BYTE_W];
            mem[wr_lo] <= wr_data[BYTE_W-1:0];
          end else begin
            mem[wr_addr] <= wr_data[BYTE_W-1:0];
          end
        end
        WK_ALL: begin
          for (int i = 0; i < DEPTH; i++)
            mem[i] <= (wide && (i % 2 == 0)) ? wr_data[2*BYTE_W-1:BYTE_W] : wr_data[BYTE_W-1:0];
        end
        default: ;
      endcase
    end
  end

  assign rd_word = wide ? {mem[rd_hi], mem[rd_lo]} : {{BYTE_W{1'b0}}, mem[rd_addr]};
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int unsigned PROG_CLKS = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(PROG_CLKS + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(PROG_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(PROG_CLKS)));
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_s,
  input  logic                 di_s,
  input  logic                 sk_rise,
  input  logic                 cs_fall,
  input  logic                 wide,
  input  logic                 busy,
  input  logic [MW_WORD_W-1:0] rd_word,
  output logic [MW_ABITS-1:0]  rd_addr,
  output logic                 fire,
  output mw_op_e               fire_op,
  output logic [MW_ABITS-1:0]  fire_addr,
  output logic [MW_WORD_W-1:0] fire_data,
  output logic                 reading,
  output logic                 do_bit
);
  typedef enum logic [2:0] { F_IDLE, F_CMD, F_DATA, F_READ, F_HOLD } fst_e;

  fst_e                  st;
  logic [4:0]            cnt;
  logic [MW_CMD_W-1:0]   sh_cmd, nxt_cmd;
  logic [MW_ABITS-1:0]   addr_q, cmd_addr;
  logic [MW_WORD_W-1:0]  data_q, rd_sh, aligned;
  logic [1:0]            opc, sub;
  logic                  load_pend;
  logic [4:0]            cmd_len, dat_len;
  mw_op_e                op_q, dec_op;
  logic                  last_cmd_bit, last_data_bit, last_rd_bit;

  assign nxt_cmd  = {sh_cmd[MW_CMD_W-2:0], di_s};
  assign cmd_len  = 5'(MW_OPC_W) + mw_addr_len(wide);
  assign dat_len  = mw_data_len(wide);
  assign opc      = wide ? nxt_cmd[MW_ABITS:MW_ABITS-1]     : nxt_cmd[MW_ABITS+1:MW_ABITS];
  assign sub      = wide ? nxt_cmd[MW_ABITS-2:MW_ABITS-3]   : nxt_cmd[MW_ABITS-1:MW_ABITS-2];
  assign cmd_addr = wide ? {1'b0, nxt_cmd[MW_ABITS-2:0]}   : nxt_cmd[MW_ABITS-1:0];
  assign dec_op   = mw_decode(opc, sub);
  assign aligned  = wide ? rd_word : {rd_word[MW_BYTE_W-1:0], {MW_BYTE_W{1'b0}}};

  assign last_cmd_bit  = (cnt == cmd_len - 5'd1);
  assign last_data_bit = (cnt == dat_len - 5'd1);
  assign last_rd_bit   = (cnt == dat_len - 5'd1);

  assign rd_addr   = addr_q;
  assign reading   = (st == F_READ);
  assign fire_op   = op_q;
  assign fire_addr = addr_q;
  assign fire_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; cnt <= '0; sh_cmd <= '0; addr_q <= '0; data_q <= '0;
      rd_sh <= '0; load_pend <= 1'b0; op_q <= OP_READ; fire <= 1'b0; do_bit <= 1'b1;
    end else begin
      fire <= 1'b0;
      if (load_pend) begin
        rd_sh     <= aligned;
        load_pend <= 1'b0;
      end
      if (cs_fall) begin
        fire <= (st == F_HOLD);
        st   <= F_IDLE;
      end else if (!cs_s) begin
        st <= F_IDLE;
      end else if (sk_rise) begin
        case (st)
          F_IDLE: if (di_s && !busy) begin
            st <= F_CMD; cnt <= '0;
          end
          F_CMD: begin
            sh_cmd <= nxt_cmd;
            if (last_cmd_bit) begin
              op_q   <= dec_op;
              addr_q <= cmd_addr;
              cnt    <= '0;
              case (dec_op)
                OP_READ: begin
                  st <= F_READ; do_bit <= 1'b0; load_pend <= 1'b1;
                end
                OP_WRITE, OP_FILL_ALL: begin
                  st <= F_DATA; data_q <= '0;
                end
                default: st <= F_HOLD;
              endcase
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
          F_DATA: begin
            data_q <= {data_q[MW_WORD_W-2:0], di_s};
            if (last_data_bit) st <= F_HOLD;
            else cnt <= cnt + 5'd1;
          end
          F_READ: begin
            do_bit <= rd_sh[MW_WORD_W-1];
            if (last_rd_bit) begin
              cnt       <= '0;
              addr_q    <= mw_next_addr(addr_q, wide);
              load_pend <= 1'b1;
            end else begin
              rd_sh <= {rd_sh[MW_WORD_W-2:0], 1'b0};
              cnt   <= cnt + 5'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'(MW_WORD_W));
  assert_busy_blocks_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F_IDLE && busy) |=> (st == F_IDLE));
  assert_read_stops_on_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !reading);
  assert_abort_no_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && st != F_HOLD) |=> !fire);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int unsigned PROG_CLKS   = 600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_out,
  output logic do_en
);
  logic                 cs_s, di_s, sk_rise, cs_fall;
  logic                 fire, reading, do_bit, busy, done, start, wen_q;
  mw_op_e               fire_op;
  logic [MW_ABITS-1:0]  fire_addr, rd_addr;
  logic [MW_WORD_W-1:0] fire_data, rd_word, wr_data;
  mw_wk_e               wr_kind;

  mw_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall));

  mw_frame frame_i (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise),
    .cs_fall(cs_fall), .wide(org), .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr),
    .fire(fire), .fire_op(fire_op), .fire_addr(fire_addr), .fire_data(fire_data),
    .reading(reading), .do_bit(do_bit));

  // programming lock, closed after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wen_q <= 1'b0;
    else if (fire && !busy) begin
      if (fire_op == OP_UNLOCK)    wen_q <= 1'b1;
      else if (fire_op == OP_LOCK) wen_q <= 1'b0;
    end
  end

  assign start = fire && mw_is_prog(fire_op) && wen_q && !busy;

  always_comb begin
    wr_kind = WK_NONE;
    if (start) wr_kind = (fire_op == OP_WRITE || fire_op == OP_ERASE) ? WK_ONE : WK_ALL;
    wr_data = (fire_op == OP_ERASE || fire_op == OP_CLR_ALL) ? '1 : fire_data;
  end

  mw_prog_timer #(.PROG_CLKS(PROG_CLKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done));

  mw_store store_i (
    .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind), .wide(org), .wr_addr(fire_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_word(rd_word));

  assign do_en  = cs_s;
  assign do_out = busy ? 1'b0 : (reading ? do_bit : 1'b1);

  assert_busy_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen_q);
  assert_busy_shows_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_en && busy) |-> !do_out);
  assert_fire_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !cs_s);
endmodule

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
  localparam int unsigned PCLK = 600;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_out, do_en;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] mdl [512];

  always #10 clk = ~clk;

  mw_eeprom #(.PROG_CLKS(PCLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_out(do_out), .do_en(do_en));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b; wait_clk(4); sk = 1'b1; wait_clk(8); sk = 1'b0; wait_clk(4);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_on;  cs = 1'b1; wait_clk(4); endtask
  task automatic cs_off; cs = 1'b0; sk = 1'b0; di = 1'b0; wait_clk(4); endtask

  function automatic logic [8:0] sub_addr(input logic [1:0] s);
    return org ? {1'b0, s, 6'b0} : {s, 7'b0};
  endfunction

  function automatic logic [15:0] mget(input int a);
    return org ? {mdl[(2*a) % 512], mdl[(2*a+1) % 512]} : {8'h00, mdl[a % 512]};
  endfunction

  task automatic mset(input int a, input logic [15:0] d);
    if (org) begin mdl[2*a] = d[15:8]; mdl[2*a+1] = d[7:0]; end
    else mdl[a] = d[7:0];
  endtask

  task automatic frame(input logic [1:0] opc, input logic [8:0] a, input logic [15:0] d, input bit has_d);
    cs_on;
    if (org) send({21'b0, 1'b1, opc, a[7:0]}, 11);
    else     send({20'b0, 1'b1, opc, a}, 12);
    if (has_d) send({16'b0, d}, org ? 16 : 8);
  endtask

  // ends a frame; checks either a busy window of the right length or no cycle at all
  task automatic finish_prog(input bit exp_busy, input string req);
    int n;
    cs_off; n = 4;
    cs_on;  n += 4;
    if (exp_busy) begin
      check(do_en && !do_out, req, {30'b0, do_en, do_out}, 32'h2);
      while (!(do_en && do_out) && n < PCLK + 100) begin wait_clk(1); n++; end
      check(n >= PCLK && n <= PCLK + 12, "R7", n, PCLK);
    end else begin
      check(do_en && do_out, req, {30'b0, do_en, do_out}, 32'h3);
    end
    cs_off;
  endtask

  task automatic read_chk(input logic [8:0] a, input int nw, input string req);
    logic [15:0] w;
    int dl, top;
    dl  = org ? 16 : 8;
    top = org ? 256 : 512;
    frame(2'b10, a, 16'h0, 1'b0);
    check(do_out == 1'b0, "R5", do_out, 0);
    for (int k = 0; k < nw; k++) begin
      w = '0;
      for (int b = 0; b < dl; b++) begin sk_bit(1'b0); w = {w[14:0], do_out}; end
      check(w == mget((a + k) % top), req, w, mget((a + k) % top));
    end
    cs_off;
  endtask

  task automatic t_reset;
    check(do_en == 1'b0, "R8", do_en, 0);
    org = 1'b1;
    read_chk(9'd5, 1, "R12");
    org = 1'b0;
    read_chk(9'd300, 1, "R12");
    org = 1'b1;
  endtask

  task automatic t_locked;
    frame(2'b01, 9'd3, 16'h1234, 1'b1);
    finish_prog(1'b0, "R4");
    read_chk(9'd3, 1, "R4");
  endtask

  task automatic t_write;
    frame(2'b00, sub_addr(2'b11), 16'h0, 1'b0); finish_prog(1'b0, "R3");
    frame(2'b01, 9'd3, 16'h1234, 1'b1); mset(3, 16'h1234); finish_prog(1'b1, "R7");
    read_chk(9'd3, 1, "R1");
    cs_on; send(32'h0, 3); send({21'b0, 3'b110, 8'd3}, 11);
    check(do_out == 1'b0, "R1", do_out, 0);
    cs_off;
  endtask

  task automatic t_org;
    org = 1'b0;
    read_chk(9'd6, 2, "R2");
    frame(2'b01, 9'd7, 16'h00A5, 1'b1); mset(7, 16'h00A5); finish_prog(1'b1, "R2");
    org = 1'b1;
    read_chk(9'd3, 1, "R2");
  endtask

  task automatic t_overwrite;
    frame(2'b01, 9'd3, 16'h00FF, 1'b1); mset(3, 16'h00FF); finish_prog(1'b1, "R9");
    frame(2'b01, 9'd3, 16'hFF00, 1'b1); mset(3, 16'hFF00); finish_prog(1'b1, "R9");
    read_chk(9'd3, 1, "R9");
    frame(2'b11, 9'd3, 16'h0, 1'b0); mset(3, 16'hFFFF); finish_prog(1'b1, "R3");
    read_chk(9'd3, 1, "R9");
  endtask

  task automatic t_wrap;
    frame(2'b01, 9'd255, 16'hBEEF, 1'b1); mset(255, 16'hBEEF); finish_prog(1'b1, "R6");
    frame(2'b01, 9'd0, 16'h1357, 1'b1); mset(0, 16'h1357); finish_prog(1'b1, "R6");
    read_chk(9'd255, 3, "R6");
  endtask

  task automatic t_busy_ignore;
    int n;
    frame(2'b01, 9'd10, 16'h1111, 1'b1); mset(10, 16'h1111);
    cs_off; cs_on;
    send({21'b0, 3'b101, 8'd11}, 11); send(32'h2222, 16);
    cs_off; cs_on; n = 0;
    while (!(do_en && do_out) && n < PCLK + 100) begin wait_clk(1); n++; end
    cs_off;
    read_chk(9'd11, 1, "R10");
    read_chk(9'd10, 1, "R10");
  endtask

  task automatic t_abort;
    cs_on; send({21'b0, 3'b101, 8'd12}, 11); send(32'h0, 6);
    finish_prog(1'b0, "R11");
    read_chk(9'd12, 1, "R11");
  endtask

  task automatic t_all;
    frame(2'b00, sub_addr(2'b01), 16'hA5C3, 1'b1); finish_prog(1'b1, "R9");
    for (int i = 0; i < 256; i++) mset(i, 16'hA5C3);
    read_chk(9'd0, 1, "R3");
    read_chk(9'd200, 1, "R9");
    frame(2'b00, sub_addr(2'b10), 16'h0, 1'b0); finish_prog(1'b1, "R9");
    for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
    read_chk(9'd77, 1, "R9");
  endtask

  task automatic t_relock;
    frame(2'b00, sub_addr(2'b00), 16'h0, 1'b0); finish_prog(1'b0, "R4");
    frame(2'b01, 9'd20, 16'h0000, 1'b1); finish_prog(1'b0, "R4");
    frame(2'b00, sub_addr(2'b01), 16'h0000, 1'b1); finish_prog(1'b0, "R4");
    read_chk(9'd20, 1, "R4");
    read_chk(9'd21, 1, "R5");
    cs = 1'b0; wait_clk(4);
    check(do_en == 1'b0, "R8", do_en, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    t_reset;
    t_locked;
    t_write;
    t_org;
    t_overwrite;
    t_wrap;
    t_busy_ignore;
    t_abort;
    t_all;
    t_relock;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule